// File: doc/BRIEF.md
# Toggle-Access State Array with Row Signature

This block holds a two-dimensional array of state bits that are open to test access by address. It needs no serial data line to every cell. In functional mode every cell loads its functional input on each clock edge, and the array drives its contents back out to the surrounding logic. In test mode the bits change only by inversion. Each toggle strobe flips the single cell selected by a row address and a column address. So, to move the array from one known state to another, the tester issues exactly one toggle for each bit that differs between the two states.

Observation works on whole rows. A row-read strobe selects one row. On the following clock edge, every bit of that row is folded into a signature register as wide as one row. The tester can read that register in parallel at any time and compare it with a value it computes offline. A flag reports that at least one row has been folded since reset. A synchronous clear input sets the signature back to zero.

Top module: `toggle_ras_sig`

## Requirements
- R1: While `rst` is high at a clock edge, every cell, `signature` and `sig_valid` become 0.
- R2: With `test_mode` = 0, every cell loads its bit of `func_d` at each clock edge, so `func_q` equals the `func_d` of the previous edge. Cell (r,c) sits at bit index r*COLS+c.
- R3: With `test_mode` = 1 and `toggle_en` = 1, the edge inverts only the cell at (`row_addr`, `col_addr`), and every other cell holds its value.
- R4: With `test_mode` = 1 and `toggle_en` = 0, every cell holds its value, and `func_d` has no effect.
- R5: With `test_mode` = 0, `toggle_en` and `read_en` are ignored: neither the cells, `signature` nor `sig_valid` change because of them.
- R6: When `read_en` is high with `test_mode` = 1 at edge k, then at edge k+1 the signature becomes {sig[COLS-2:0],0} XOR (sig[COLS-1] ? POLY : 0) XOR row. Here row is the array row named by the `row_addr` sampled at edge k, read as it stands after edge k.
- R7: A toggle and a row read in the same cycle are ordered toggle first: the folded row already contains the inverted bit.
- R8: `sig_clear` high at an edge makes `signature` 0 after that edge in either mode, and it takes priority over a fold due at that edge. It leaves `sig_valid` and the cells unchanged.
- R9: `sig_valid` rises at the edge of the first fold after reset and then stays high until `rst`.
- R10: Starting from state A, toggling each differing cell once turns `func_q` into state B. The number of toggles is the Hamming distance between A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects test access, 0 selects functional capture |
| row_addr | input | $clog2(ROWS) | Row selected for a toggle or a read |
| col_addr | input | $clog2(COLS) | Column selected for a toggle |
| toggle_en | input | 1 | Invert the addressed cell |
| read_en | input | 1 | Fold the addressed row into the signature |
| sig_clear | input | 1 | Synchronous clear of the signature |
| func_d | input | ROWS*COLS | Functional data into the cells |
| func_q | output | ROWS*COLS | Registered cell contents |
| signature | output | COLS | Row signature register |
| sig_valid | output | 1 | At least one row folded since reset |

## Verification
A toggle, a functional capture or a clear shows on `func_q` or `signature` at the same edge that samples it. A row fold shows one edge later, because the read request is registered first. The bench drives each strobe for exactly one edge, leaves one idle edge after it, and samples one time unit after the second edge. At that point both the one-edge and the two-edge results have settled. The reference signature is computed in the bench from the R6 formula, applied to a bit model of the array that is updated in toggle-first order.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int DEF_COLS = 8;
  localparam int DEF_ROWS = 4;
  localparam logic [7:0] DEF_POLY = 8'h1D;  // x^8+x^4+x^3+x^2+1
endpackage

// File: rtl/trs_addr_dec.sv
module trs_addr_dec #(
  parameter int N  = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  output logic [N-1:0]  hot
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hot[i] = en && (addr == AW'(i));
  end
endmodule

// File: rtl/trs_cell_array.sv
module trs_cell_array #(
  parameter int COLS = 8,
  parameter int ROWS = 4,
  localparam int NB = COLS * ROWS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            test_mode,
  input  logic            toggle_en,
  input  logic [ROWS-1:0] row_hot,
  input  logic [COLS-1:0] col_hot,
  input  logic [NB-1:0]   func_d,
  output logic [NB-1:0]   state
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      always_ff @(posedge clk) begin
        if (rst)
          state[IDX] <= 1'b0;
        else if (!test_mode)
          state[IDX] <= func_d[IDX];
        else if (row_hot[r] && col_hot[c])
          state[IDX] <= ~state[IDX];
      end
    end
  end

  a_r2_func_capture: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> state == $past(func_d));
  a_r3_single_flip: assert property (@(posedge clk) disable iff (rst)
    (test_mode && toggle_en) |=> $countones(state ^ $past(state)) == 1);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !toggle_en) |=> $stable(state));
endmodule

// File: rtl/trs_misr.sv
module trs_misr #(
  parameter int COLS = 8,
  parameter logic [COLS-1:0] POLY = 8'h1D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            fold,
  input  logic [COLS-1:0] row_data,
  output logic [COLS-1:0] sig,
  output logic            valid
);
  logic [COLS-1:0] nxt;

  always_comb begin
    nxt = {sig[COLS-2:0], 1'b0} ^ row_data;
    if (sig[COLS-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig   <= '0;
      valid <= 1'b0;
    end else begin
      if (clear)     sig <= '0;
      else if (fold) sig <= nxt;
      if (fold) valid <= 1'b1;
    end
  end

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> sig == '0);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !fold) |=> $stable(sig));
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
  a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(fold));
endmodule

// File: rtl/toggle_ras_sig.sv
module toggle_ras_sig
  import trs_pkg::*;
#(
  parameter int COLS = DEF_COLS,
  parameter int ROWS = DEF_ROWS,
  parameter logic [COLS-1:0] POLY = DEF_POLY,
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int NB  = COLS * ROWS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            test_mode,
  input  logic [RAW-1:0]  row_addr,
  input  logic [CAW-1:0]  col_addr,
  input  logic            toggle_en,
  input  logic            read_en,
  input  logic            sig_clear,
  input  logic [NB-1:0]   func_d,
  output logic [NB-1:0]   func_q,
  output logic [COLS-1:0] signature,
  output logic            sig_valid
);
  logic [ROWS-1:0] row_hot;
  logic [COLS-1:0] col_hot;
  logic            tog_act;
  logic            rd_pend;
  logic [RAW-1:0]  row_pend;
  logic [COLS-1:0] row_data;

  assign tog_act = test_mode && toggle_en;

  trs_addr_dec #(.N(ROWS)) u_rdec (.addr(row_addr), .en(tog_act), .hot(row_hot));
  trs_addr_dec #(.N(COLS)) u_cdec (.addr(col_addr), .en(tog_act), .hot(col_hot));

  trs_cell_array #(.COLS(COLS), .ROWS(ROWS)) u_arr (
    .clk(clk), .rst(rst), .test_mode(test_mode), .toggle_en(toggle_en),
    .row_hot(row_hot), .col_hot(col_hot), .func_d(func_d), .state(func_q));

  // Read request is registered so the fold sees the array after any
  // toggle taken at the same edge (toggle-first ordering).
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      row_pend <= '0;
    end else begin
      rd_pend  <= test_mode && read_en;
      row_pend <= row_addr;
    end
  end

  assign row_data = func_q[int'(row_pend) * COLS +: COLS];

  trs_misr #(.COLS(COLS), .POLY(POLY)) u_misr (
    .clk(clk), .rst(rst), .clear(sig_clear), .fold(rd_pend),
    .row_data(row_data), .sig(signature), .valid(sig_valid));

  a_r5_no_read_func: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !sig_clear && !rd_pend) |=> $stable(signature));
  a_r7_fold_follows: assert property (@(posedge clk) disable iff (rst)
    (test_mode && read_en) |=> rd_pend);
endmodule

// File: tb/sim_toggle_ras_sig.sv
module sim_toggle_ras_sig;
  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int NB = COLS * ROWS;
  localparam logic [7:0] POLY = 8'h1D;

  // op[7:6]: 0 toggle, 1 read, 2 toggle+read; op[5:4] row; op[2:0] col
  localparam int NOPS = 12;
  localparam logic [7:0] OPS [NOPS] = '{
    8'h03, 8'h40, 8'h17, 8'h50, 8'hA5, 8'h26,
    8'h60, 8'h31, 8'hB1, 8'h70, 8'h84, 8'h52};

  logic clk = 0, rst = 1, test_mode = 0, toggle_en = 0, read_en = 0, sig_clear = 0;
  logic [1:0] row_addr = 0;
  logic [2:0] col_addr = 0;
  logic [NB-1:0] func_d = 0, func_q;
  logic [COLS-1:0] signature;
  logic sig_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NB-1:0] m_state;
  logic [COLS-1:0] m_sig;

  always #2.5 clk = ~clk;

  toggle_ras_sig u0 (.clk, .rst, .test_mode, .row_addr, .col_addr, .toggle_en,
    .read_en, .sig_clear, .func_d, .func_q, .signature, .sig_valid);

  function automatic logic [COLS-1:0] step(logic [COLS-1:0] s, logic [COLS-1:0] row);
    logic [COLS-1:0] n;
    n = {s[COLS-2:0], 1'b0} ^ row;
    if (s[COLS-1]) n = n ^ POLY;
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: strobes for one edge, one idle edge, sample 1 unit later
  task automatic access(bit tg, bit rd, int r, int c);
    row_addr = 2'(r); col_addr = 3'(c); toggle_en = tg; read_en = rd;
    @(posedge clk); #1;
    toggle_en = 0; read_en = 0;
    @(posedge clk); #1;
    if (tg) m_state[r*COLS + c] = ~m_state[r*COLS + c];
    if (rd) m_sig = step(m_sig, m_state[r*COLS +: COLS]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    func_d = 32'hFFFF_FFFF;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 state", func_q, 0);
    chk("R1 sig", signature, 0);
    chk("R1 valid", sig_valid, 0);
    rst = 0;

    func_d = 32'hA5C3_5A17;
    @(posedge clk); #1;
    chk("R2 capture", func_q, 32'hA5C3_5A17);
    func_d = 32'h1234_9876;
    @(posedge clk); #1;
    chk("R2 capture2", func_q, 32'h1234_9876);
    m_state = 32'h1234_9876; m_sig = 0;

    test_mode = 1;
    func_d = 32'h0;
    @(posedge clk); #1;
    chk("R4 func_d ignored", func_q, m_state);

    for (int i = 0; i < NOPS; i++) begin
      logic [7:0] op;
      bit was_valid;
      op = OPS[i];
      was_valid = sig_valid;
      access(op[7:6] != 1, op[7:6] != 0, int'(op[5:4]), int'(op[2:0]));
      chk(op[7:6] == 2 ? "R7 toggle-first" : "R3 cells", func_q, m_state);
      chk(op[7:6] == 0 ? "R3 sig untouched" : "R6 signature", signature, m_sig);
      if (!was_valid && op[7:6] != 0) chk("R9 valid rise", sig_valid, 1);
    end

    access(0, 0, 1, 1);
    chk("R4 hold", func_q, m_state);

    // R8: clear wins over a fold due at the same edge
    read_en = 1; row_addr = 2;
    @(posedge clk); #1;
    read_en = 0; sig_clear = 1;
    @(posedge clk); #1;
    sig_clear = 0;
    chk("R8 clear", signature, 0);
    chk("R8 valid kept", sig_valid, 1);
    chk("R8 cells kept", func_q, m_state);
    m_sig = 0;

    // R5: functional mode, strobes ignored
    test_mode = 0; func_d = m_state;
    toggle_en = 1; read_en = 1; row_addr = 0; col_addr = 0;
    @(posedge clk); #1;
    toggle_en = 0; read_en = 0;
    @(posedge clk); #1;
    chk("R5 no toggle", func_q, m_state);
    chk("R5 no fold", signature, 0);

    // R10: A -> B with Hamming-distance toggles
    begin
      logic [NB-1:0] tgt;
      int n;
      tgt = 32'hF0F0_0F0F; n = 0;
      func_d = 32'h0FF0_33CC; m_state = func_d;
      @(posedge clk); #1;
      test_mode = 1;
      for (int b = 0; b < NB; b++)
        if (m_state[b] != tgt[b]) begin
          access(1, 0, b / COLS, b % COLS);
          n++;
        end
      chk("R10 target", func_q, tgt);
      chk("R10 count", 64'(n), 64'($countones(32'h0FF0_33CC ^ tgt)));
    end

    rst = 1;
    @(posedge clk); #1;
    chk("R1 valid reset", sig_valid, 0);
    rst = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule